// File: doc/BRIEF.md
# Character-Oriented Synchronous Receiver with Sync Hunt

This block receives a sampled serial bit stream on a character-oriented synchronous link. While hunting, it slides each new bit into a window and compares the window with a programmed sync pattern. The pattern can be one 8-bit character, a 16-bit pattern, or a 12-bit pattern. In a fourth mode no pattern is compared, and an external marker input starts the information field. Once it has locked, the block groups the following bits into 8-bit characters, most significant bit first, and queues them.

A bit-serial CRC-16 runs over every character received after lock. Software pulses the end-of-message input before the last CRC byte arrives. When that byte completes, the block checks the CRC remainder and queues the result as an error flag beside the character. Data and flag sit in two 4-entry queues that advance in lockstep. A read port pops both queues at once. A sticky overrun flag records a character that arrived while the queues were full. A synchronous hunt command drops lock and restarts the search.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, empty_o is 1, sync_o is 0 and overrun_o is 0.
- R2: In single-character mode (mode_i = 0), sync_o rises on the bit-enable cycle in which the last 8 received bits equal sync_pat_i[7:0]. Bits that do not complete the pattern leave sync_o at 0. The sync character is not queued.
- R3: In 16-bit mode (mode_i = 1), lock needs all 16 most recent bits to equal sync_pat_i. A match of only the low 12 bits does not lock.
- R4: In 12-bit mode (mode_i = 2), only the 12 most recent bits are compared, against sync_pat_i[11:0]. sync_pat_i[15:12] has no effect.
- R5: In external mode (mode_i = 3), a bit-enable cycle with ext_sync_i high while hunting sets sync_o. The bit of that cycle is discarded, and the next enabled bit is the MSB of the first character. ext_sync_i has no effect once locked.
- R6: While locked, each group of 8 enabled bits is queued as one character, MSB first, in arrival order. The head character appears on rx_data_o.
- R7: The CRC is x^16+x^15+x^2+1, preset to zero on lock and after each checked character. An eom_i pulse arms a check on the next completed character. That character's flag is 0 when the remainder after it is zero. Characters without an armed check carry flag 0.
- R8: A message whose final CRC byte is corrupted queues that byte with crc_err_o = 1.
- R9: The queues hold 4 entries. A character completed while they are full and no read is issued is dropped and sets overrun_o. overrun_o stays set until a hunt command clears it. The four held entries are unchanged.
- R10: hunt_i drops sync_o on the next cycle, clears the partial character and the overrun flag, and returns the receiver to pattern search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies rxd_i and ext_sync_i for one cycle |
| rxd_i | input | 1 | Serial data bit |
| ext_sync_i | input | 1 | External start-of-field marker (mode 3) |
| mode_i | input | 2 | 0 single char, 1 16-bit, 2 12-bit, 3 external |
| sync_pat_i | input | 16 | Programmed sync pattern |
| hunt_i | input | 1 | Synchronous enter-hunt command |
| eom_i | input | 1 | Arms a CRC check on the next completed character |
| rd_i | input | 1 | Pops the head entry of both queues |
| rx_data_o | output | 8 | Head character |
| crc_err_o | output | 1 | Error flag queued with the head character |
| empty_o | output | 1 | Queues empty |
| sync_o | output | 1 | Receiver locked |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach is the one where the CRC flag must line up with exactly one character. The armed check has to land on the last CRC byte, and the remainder must return to zero so that the next message in the same lock starts clean. The stimulus covers this with a sweep over sync patterns. Each pass sends a two-byte message with a CRC computed in the bench and corrupts the final byte on alternate passes. It then sends a second message without hunting again, so a CRC register left dirty would flag it. Near-miss patterns, such as a 12-bit match in 16-bit mode, show that the comparison width follows the mode.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic [1:0] {
    MODE_MONO = 2'd0,
    MODE_BI16 = 2'd1,
    MODE_BI12 = 2'd2,
    MODE_EXT  = 2'd3
  } hunt_mode_e;

  localparam logic [15:0] CRC_POLY = 16'h8005;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/sync_hunt_det.sv
module sync_hunt_det
  import sync_rx_pkg::*;
#(
  parameter int SYNC_W  = 16,
  parameter int SHORT_W = 12,
  parameter int CHAR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              rxd_i,
  input  logic              ext_sync_i,
  input  hunt_mode_e        mode_i,
  input  logic [SYNC_W-1:0] pat_i,
  input  logic              hunt_i,
  output logic              sync_o,
  output logic              hit_o
);
  logic [SYNC_W-1:0] sr_q, sr_next;
  logic              sync_q, match;

  assign sr_next = {sr_q[SYNC_W-2:0], rxd_i};

  always_comb begin
    unique case (mode_i)
      MODE_MONO: match = (sr_next[CHAR_W-1:0] == pat_i[CHAR_W-1:0]);
      MODE_BI16: match = (sr_next == pat_i);
      MODE_BI12: match = (sr_next[SHORT_W-1:0] == pat_i[SHORT_W-1:0]);
      default:   match = ext_sync_i;
    endcase
  end

  assign hit_o  = bit_en_i && !sync_q && !hunt_i && match;
  assign sync_o = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      sync_q <= 1'b0;
    end else if (hunt_i) begin
      sr_q   <= '0;
      sync_q <= 1'b0;
    end else begin
      if (bit_en_i) sr_q <= sr_next;
      if (hit_o) sync_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import sync_rx_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              rxd_i,
  input  logic              sync_i,
  input  logic              hit_i,
  input  logic              hunt_i,
  input  logic              eom_i,
  output logic              push_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(CHAR_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [CHAR_W-1:0] char_q, char_next;
  logic [15:0]       crc_q, crc_next;
  logic              chk_q, take, last, armed;

  assign take      = sync_i && bit_en_i && !hunt_i;
  assign last      = take && (cnt_q == CNT_W'(CHAR_W - 1));
  assign char_next = {char_q[CHAR_W-2:0], rxd_i};
  assign crc_next  = crc_step(crc_q, rxd_i);
  assign armed     = chk_q || eom_i;

  assign push_o = last;
  assign char_o = char_next;
  assign err_o  = armed && (crc_next != 16'h0000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      char_q <= '0;
      crc_q  <= '0;
      chk_q  <= 1'b0;
    end else if (hunt_i || hit_i) begin
      cnt_q <= '0;
      crc_q <= '0;
      chk_q <= 1'b0;
    end else begin
      if (last) chk_q <= 1'b0;
      else if (eom_i) chk_q <= 1'b1;
      if (take) begin
        cnt_q  <= last ? '0 : cnt_q + 1'b1;
        char_q <= char_next;
        crc_q  <= (last && armed) ? 16'h0000 : crc_next;
      end
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= wr_q + 1'b1;
      end
      if (do_pop) rd_q <= rd_q + 1'b1;
      if (do_push && !do_pop) cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
  import sync_rx_pkg::*;
#(
  parameter int SYNC_W  = 16,
  parameter int SHORT_W = 12,
  parameter int CHAR_W  = 8,
  parameter int DEPTH   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              rxd_i,
  input  logic              ext_sync_i,
  input  logic [1:0]        mode_i,
  input  logic [SYNC_W-1:0] sync_pat_i,
  input  logic              hunt_i,
  input  logic              eom_i,
  input  logic              rd_i,
  output logic [CHAR_W-1:0] rx_data_o,
  output logic              crc_err_o,
  output logic              empty_o,
  output logic              sync_o,
  output logic              overrun_o
);
  hunt_mode_e        mode_s;
  logic              hit_w, push_w, err_w, full_w, ovr_q;
  logic [CHAR_W-1:0] char_w;
  logic              d_empty, d_full, e_empty, e_full;

  assign mode_s = hunt_mode_e'(mode_i);

  sync_hunt_det #(.SYNC_W(SYNC_W), .SHORT_W(SHORT_W), .CHAR_W(CHAR_W)) u_det (
    .clk_i, .rst_ni, .bit_en_i, .rxd_i, .ext_sync_i,
    .mode_i (mode_s),
    .pat_i  (sync_pat_i),
    .hunt_i,
    .sync_o,
    .hit_o  (hit_w)
  );

  rx_deframer #(.CHAR_W(CHAR_W)) u_dfr (
    .clk_i, .rst_ni, .bit_en_i, .rxd_i,
    .sync_i (sync_o),
    .hit_i  (hit_w),
    .hunt_i, .eom_i,
    .push_o (push_w),
    .char_o (char_w),
    .err_o  (err_w)
  );

  rx_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_dfifo (
    .clk_i, .rst_ni,
    .push_i (push_w), .din_i (char_w), .pop_i (rd_i),
    .dout_o (rx_data_o), .empty_o (d_empty), .full_o (d_full)
  );

  rx_fifo #(.W(1), .DEPTH(DEPTH)) u_efifo (
    .clk_i, .rst_ni,
    .push_i (push_w), .din_i (err_w), .pop_i (rd_i),
    .dout_o (crc_err_o), .empty_o (e_empty), .full_o (e_full)
  );

  assign empty_o = d_empty | e_empty;
  assign full_w  = d_full | e_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else if (hunt_i) ovr_q <= 1'b0;
    else if (push_w && full_w && !rd_i) ovr_q <= 1'b1;
  end
  assign overrun_o = ovr_q;
endmodule

// File: rtl/sync_hunt_rx_chk.sv
module sync_hunt_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       ext_sync_i,
  input logic [1:0] mode_i,
  input logic       hunt_i,
  input logic       rd_i,
  input logic       sync_o,
  input logic       overrun_o,
  input logic       push_w,
  input logic       full_w
);
  // R10
  hunt_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_i |=> !sync_o);
  // R2
  lock_on_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(bit_en_i));
  // R5
  ext_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !sync_o && bit_en_i && ext_sync_i && !hunt_i) |=> sync_o);
  // R6
  push_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_w |-> sync_o);
  // R9
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_w && full_w && !rd_i && !hunt_i) |=> overrun_o);
  // R9
  overrun_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !hunt_i) |=> overrun_o);
endmodule

bind sync_hunt_rx sync_hunt_rx_chk u_chk (.*);

// File: tb/sync_hunt_rx_test.sv
module sync_hunt_rx_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0, rxd_i = 1'b0, ext_sync_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [15:0] sync_pat_i = 16'h0;
  logic        hunt_i = 1'b0, eom_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  rx_data_o;
  logic        crc_err_o, empty_o, sync_o, overrun_o;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sync_hunt_rx uut (.*);

  function automatic logic [15:0] crc_bytes(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] c = 16'h0;
    logic [15:0] m = {a, b};
    for (int k = 15; k >= 0; k--)
      c = c[15] ^ m[k] ? ({c[14:0], 1'b0} ^ 16'h8005) : {c[14:0], 1'b0};
    return c;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic ex);
    @(negedge clk_i);
    rxd_i = b; ext_sync_i = ex; bit_en_i = 1'b1;
    @(negedge clk_i);
    bit_en_i = 1'b0; ext_sync_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic ex);
    for (int k = 7; k >= 0; k--) send_bit(v[k], ex);
  endtask

  task automatic send_ones(input int n);
    for (int k = 0; k < n; k++) send_bit(1'b1, 1'b0);
  endtask

  task automatic do_hunt();
    @(negedge clk_i); hunt_i = 1'b1;
    @(negedge clk_i); hunt_i = 1'b0;
  endtask

  task automatic pulse_eom();
    @(negedge clk_i); eom_i = 1'b1;
    @(negedge clk_i); eom_i = 1'b0;
  endtask

  task automatic pop_check(input logic [7:0] ed, input logic ee, input string req);
    chk(!empty_o, req, empty_o, 0);
    chk(rx_data_o == ed, req, rx_data_o, ed);
    chk(crc_err_o == ee, req, crc_err_o, ee);
    rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  pats [4] = '{8'h16, 8'h32, 8'h7E, 8'h4B};
    logic [15:0] c;
    logic [7:0]  d0, d1;
    logic        bad;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(empty_o == 1'b1, "R1", empty_o, 1);
    chk(sync_o == 1'b0, "R1", sync_o, 0);
    chk(overrun_o == 1'b0, "R1", overrun_o, 0);

    // R2 R6 R7 R8: sweep over single-character patterns
    for (int i = 0; i < 4; i++) begin
      do_hunt();
      mode_i = 2'd0; sync_pat_i = {8'hA5, pats[i]};
      send_ones(8);
      chk(sync_o == 1'b0, "R2", sync_o, 0);
      send_byte(pats[i], 1'b0);
      chk(sync_o == 1'b1, "R2", sync_o, 1);
      chk(empty_o == 1'b1, "R2", empty_o, 1);
      d0 = pats[i] ^ 8'hC3; d1 = 8'(i * 37 + 5);
      c = crc_bytes(d0, d1);
      bad = i[0];
      send_byte(d0, 1'b0); send_byte(d1, 1'b0); send_byte(c[15:8], 1'b0);
      pulse_eom();
      send_byte(c[7:0] ^ {7'd0, bad}, 1'b0);
      chk(overrun_o == 1'b0, "R9", overrun_o, 0);
      pop_check(d0, 1'b0, "R6");
      pop_check(d1, 1'b0, "R6");
      pop_check(c[15:8], 1'b0, "R7");
      pop_check(c[7:0] ^ {7'd0, bad}, bad, bad ? "R8" : "R7");
      // second message in same lock: remainder must start at zero
      d0 = 8'(i + 8'h90); d1 = ~d0;
      c = crc_bytes(d0, d1);
      send_byte(d0, 1'b0); send_byte(d1, 1'b0); send_byte(c[15:8], 1'b0);
      pulse_eom();
      send_byte(c[7:0], 1'b0);
      pop_check(d0, 1'b0, "R6");
      pop_check(d1, 1'b0, "R6");
      pop_check(c[15:8], 1'b0, "R7");
      pop_check(c[7:0], 1'b0, "R7");
    end

    // R3: 12-bit match is not enough in 16-bit mode
    do_hunt();
    mode_i = 2'd1; sync_pat_i = 16'h3A5C;
    send_ones(16);
    for (int k = 11; k >= 0; k--) send_bit(sync_pat_i[k], 1'b0);
    chk(sync_o == 1'b0, "R3", sync_o, 0);
    do_hunt();
    send_ones(16);
    for (int k = 15; k >= 0; k--) send_bit(sync_pat_i[k], 1'b0);
    chk(sync_o == 1'b1, "R3", sync_o, 1);
    send_byte(8'hC3, 1'b0);
    pop_check(8'hC3, 1'b0, "R3");

    // R4: 12-bit mode ignores pattern bits 15:12
    do_hunt();
    mode_i = 2'd2;
    send_ones(16);
    for (int k = 11; k >= 0; k--) send_bit(sync_pat_i[k], 1'b0);
    chk(sync_o == 1'b1, "R4", sync_o, 1);
    send_byte(8'h69, 1'b0);
    pop_check(8'h69, 1'b0, "R4");

    // R5: external marker
    do_hunt();
    mode_i = 2'd3;
    for (int k = 0; k < 10; k++) send_bit(k[0], 1'b0);
    chk(sync_o == 1'b0, "R5", sync_o, 0);
    send_bit(1'b1, 1'b1);
    chk(sync_o == 1'b1, "R5", sync_o, 1);
    chk(empty_o == 1'b1, "R5", empty_o, 1);
    send_byte(8'h81, 1'b0);
    pop_check(8'h81, 1'b0, "R5");
    send_byte(8'h42, 1'b1);
    pop_check(8'h42, 1'b0, "R5");

    // R10: hunt mid-character
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    do_hunt();
    chk(sync_o == 1'b0, "R10", sync_o, 0);
    send_bit(1'b0, 1'b1);
    send_byte(8'h3C, 1'b0);
    pop_check(8'h3C, 1'b0, "R10");
    chk(empty_o == 1'b1, "R10", empty_o, 1);

    // R9: overrun
    do_hunt();
    mode_i = 2'd0; sync_pat_i = 16'h0016;
    send_ones(8);
    send_byte(8'h16, 1'b0);
    for (int k = 0; k < 5; k++) send_byte(8'(8'h10 + k), 1'b0);
    chk(overrun_o == 1'b1, "R9", overrun_o, 1);
    for (int k = 0; k < 4; k++) pop_check(8'(8'h10 + k), 1'b0, "R9");
    chk(empty_o == 1'b1, "R9", empty_o, 1);
    chk(overrun_o == 1'b1, "R9", overrun_o, 1);
    do_hunt();
    chk(overrun_o == 1'b0, "R10", overrun_o, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule